// File: doc/BRIEF.md
# Core Interrupt Flag and Mask Unit

This unit sits between a set of interrupt request lines and a processor core. Each line is edge-detected and latched into a flag bit. A flagged line becomes eligible only when its own enable bit is 1. The whole unit is additionally gated by one global mask bit that is active-low: 0 lets requests through and 1 holds them back. Of the eligible lines, the lowest-numbered one is offered to the core on a valid/ready handshake.

The core takes a request by raising ready while valid is high. In that cycle the unit clears the winning flag, saves the mask value then in force, and sets the mask to 1 so that nothing nests. When the core pulses the return input, the saved mask value is restored and the next pending request may be offered. Lines 1 to 12 carry the peripheral expander outputs, and lines 13 and 14 carry two timer sources.

A plain register port lets software overwrite the flags, OR or AND the enable mask, and write the global mask. The unit ignores back-pressure in one sense only: while valid is high and ready is low, nothing is lost. Every flag stays pending, and the offered line always names the lowest eligible line at that moment.

Top module: `irqfm_top`

## Requirements
- R1: After reset all flags are 0, all enables are 0, the global mask is 1 (disabled) and `irq_valid_o` is 0.
- R2: A rising edge on `req_i[i]` sets `flags_o[i]` at the next clock edge, whatever the state of `enables_o[i]` and of the global mask.
- R3: `irq_valid_o` is 1 exactly when some bit is set in both `flags_o` and `enables_o` and `gmask_o` is 0.
- R4: While valid, `irq_line_o` is the lowest bit index i with flag and enable both set. Bit i carries line i+1, so bits 12 and 13 are the two timer lines.
- R5: A cycle with `irq_valid_o`=1 and `irq_ready_i`=0 changes no flag and no mask bit. The request stays offered.
- R6: On acceptance (`irq_valid_o` and `irq_ready_i` both 1), the winning flag clears and `gmask_o` becomes 1 at the next edge. The previous mask value is saved.
- R7: If a rising edge arrives on the winning line in the acceptance cycle, that flag stays set.
- R8: A `ret_i` pulse restores `gmask_o` to the saved value. If acceptance and return occur in the same cycle, acceptance wins.
- R9: Write op 1 ORs `wr_data_i` into the enables. Write op 2 ANDs `wr_data_i` into the enables.
- R10: Write op 0 replaces the flags with `wr_data_i`, but rising edges in that cycle still set their flags. Write op 3 loads `wr_data_i[0]` into the global mask unless acceptance or return occurs in that cycle.
- R11: While `gmask_o` is 1, flagged lines remain set and are offered once the mask returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_LINES | Request lines, rising edge flags |
| irq_valid_o | output | 1 | A request is offered to the core |
| irq_ready_i | input | 1 | Core accepts the offered request |
| irq_line_o | output | IW | Bit index of the offered line |
| ret_i | input | 1 | Service routine has returned |
| wr_en_i | input | 1 | Register write strobe |
| wr_op_i | input | 2 | 0 flag write, 1 enable OR, 2 enable AND, 3 mask write |
| wr_data_i | input | NUM_LINES | Write data |
| flags_o | output | NUM_LINES | Current flag bits |
| enables_o | output | NUM_LINES | Current enable bits |
| gmask_o | output | 1 | Global mask, 0 = enabled |

## Verification
The bench builds the unit with the default of 14 lines, which gives a 4-bit line index. This setting makes the two timer lines at the top bit positions reachable, so priority can be checked against the widest index. A behavioural model steps alongside the design through directed scenarios: held-off handshakes, acceptance colliding with a new edge, and a return that follows a software write to the mask. A long randomized phase then mixes sparse requests, random ready, rare returns and every write op, so that acceptance, return and software writes collide in the same cycle.

// File: rtl/irqfm_pkg.sv
package irqfm_pkg;
  typedef enum logic [1:0] {
    OP_FLAG_WR  = 2'd0,
    OP_EN_OR    = 2'd1,
    OP_EN_AND   = 2'd2,
    OP_GMASK_WR = 2'd3
  } reg_op_e;
endpackage

// File: rtl/irqfm_edge.sv
module irqfm_edge #(
  parameter int N = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= req_i;
  end

  assign rise_o = req_i & ~prev_q;
endmodule

// File: rtl/irqfm_pick.sv
module irqfm_pick #(
  parameter int N  = 14,
  parameter int IW = 4
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] win;

  // one-hot winner: a bit wins when no lower bit is pending
  for (genvar i = 0; i < N; i++) begin : g_win
    if (i == 0) begin : g_first
      assign win[i] = pend_i[i];
    end else begin : g_rest
      assign win[i] = pend_i[i] & ~(|pend_i[i-1:0]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/irqfm_gmask.sv
module irqfm_gmask (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic ret_i,
  input  logic sw_wr_i,
  input  logic sw_val_i,
  output logic gmask_o
);
  logic gm_q, saved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gm_q    <= 1'b1;
      saved_q <= 1'b1;
    end else if (accept_i) begin
      saved_q <= gm_q;
      gm_q    <= 1'b1;
    end else if (ret_i) begin
      gm_q    <= saved_q;
    end else if (sw_wr_i) begin
      gm_q    <= sw_val_i;
    end
  end

  assign gmask_o = gm_q;

  // R6
  mask_set_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> gmask_o);

  // R8
  mask_restore_on_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !accept_i) |=> (gmask_o == $past(saved_q)));
endmodule

// File: rtl/irqfm_top.sv
module irqfm_top #(
  parameter int NUM_LINES = 14,
  localparam int IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 irq_valid_o,
  input  logic                 irq_ready_i,
  output logic [IW-1:0]        irq_line_o,
  input  logic                 ret_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_op_i,
  input  logic [NUM_LINES-1:0] wr_data_i,
  output logic [NUM_LINES-1:0] flags_o,
  output logic [NUM_LINES-1:0] enables_o,
  output logic                 gmask_o
);
  import irqfm_pkg::*;

  logic [NUM_LINES-1:0] flags_q, en_q, rise, pend, clr_mask, flag_base;
  logic                 any_pend, accept;
  logic [IW-1:0]        win_idx;

  irqfm_edge #(.N(NUM_LINES)) edge_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .rise_o(rise)
  );

  assign pend = flags_q & en_q;

  irqfm_pick #(.N(NUM_LINES), .IW(IW)) pick_i (
    .pend_i(pend), .any_o(any_pend), .idx_o(win_idx)
  );

  assign irq_valid_o = any_pend & ~gmask_o;
  assign irq_line_o  = win_idx;
  assign accept      = irq_valid_o & irq_ready_i;
  assign clr_mask    = accept ? (NUM_LINES'(1) << win_idx) : '0;
  assign flag_base   = (wr_en_i && wr_op_i == OP_FLAG_WR) ? wr_data_i : flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= (flag_base & ~clr_mask) | rise;
      if (wr_en_i && wr_op_i == OP_EN_OR)  en_q <= en_q | wr_data_i;
      if (wr_en_i && wr_op_i == OP_EN_AND) en_q <= en_q & wr_data_i;
    end
  end

  irqfm_gmask gmask_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .ret_i(ret_i),
    .sw_wr_i(wr_en_i && wr_op_i == OP_GMASK_WR), .sw_val_i(wr_data_i[0]),
    .gmask_o(gmask_o)
  );

  assign flags_o   = flags_q;
  assign enables_o = en_q;

  // R2
  edge_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((flags_o & $past(rise)) == $past(rise)));

  // R3
  valid_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (!gmask_o && flags_o[irq_line_o] && enables_o[irq_line_o]));

  // R4
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> ((flags_o & enables_o & ((NUM_LINES'(1) << irq_line_o) - 1'b1)) == '0));

  // R6
  flag_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !rise[irq_line_o]) |=> !flags_o[$past(irq_line_o)]);

  // R7
  flag_kept_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && rise[irq_line_o]) |=> flags_o[$past(irq_line_o)]);

  // R9
  enable_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_op_i == 2'd1) |=> (enables_o == ($past(enables_o) | $past(wr_data_i))));
endmodule

// File: tb/irqfm_top_tb_top.sv
`timescale 1ns/1ps
module irqfm_top_tb_top;
  localparam int N  = 14;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          ready = 1'b0, ret = 1'b0, wr_en = 1'b0;
  logic [1:0]    wr_op = 2'd0;
  logic [N-1:0]  wr_data = '0;
  logic          valid, gmask;
  logic [IW-1:0] line;
  logic [N-1:0]  flags, enables;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  irqfm_top #(.NUM_LINES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .irq_valid_o(valid),
    .irq_ready_i(ready), .irq_line_o(line), .ret_i(ret), .wr_en_i(wr_en),
    .wr_op_i(wr_op), .wr_data_i(wr_data), .flags_o(flags),
    .enables_o(enables), .gmask_o(gmask)
  );

  // behavioural reference model
  logic [N-1:0] m_flag = '0, m_en = '0, m_prev = '0;
  logic         m_gm = 1'b1, m_sav = 1'b1;

  function automatic int m_low(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic m_valid();
    return ((m_flag & m_en) != '0) && !m_gm;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_flag = '0; m_en = '0; m_prev = '0; m_gm = 1'b1; m_sav = 1'b1;
    end else begin
      logic [N-1:0] rise, nf;
      logic acc;
      int w;
      rise = req & ~m_prev;
      m_prev = req;
      w = m_low(m_flag & m_en);
      acc = m_valid() && ready;
      nf = (wr_en && wr_op == 2'd0) ? wr_data : m_flag;
      if (acc) nf[w] = 1'b0;
      m_flag = nf | rise;
      if (wr_en && wr_op == 2'd1) m_en = m_en | wr_data;
      if (wr_en && wr_op == 2'd2) m_en = m_en & wr_data;
      if (acc) begin m_sav = m_gm; m_gm = 1'b1; end
      else if (ret) m_gm = m_sav;
      else if (wr_en && wr_op == 2'd3) m_gm = wr_data[0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 R6 R7 R10 R11 flags", 32'(flags), 32'(m_flag));
      chk("R9 enables", 32'(enables), 32'(m_en));
      chk("R6 R8 R10 gmask", 32'(gmask), 32'(m_gm));
      chk("R3 R5 valid", 32'(valid), 32'(m_valid()));
      if (m_valid()) chk("R4 line", 32'(line), 32'(m_low(m_flag & m_en)));
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] op, input logic [N-1:0] d);
    wr_en = 1'b1; wr_op = op; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_req(input logic [N-1:0] r);
    req = r; tick(); req = '0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 flags", 32'(flags), 0);
    chk("R1 enables", 32'(enables), 0);
    chk("R1 gmask", 32'(gmask), 1);
    chk("R1 valid", 32'(valid), 0);

    pulse_req(14'h0020);
    chk("R2 flag set while disabled", 32'(flags), 32'h20);
    wr(2'd3, '0);
    chk("R3 no valid without enable", 32'(valid), 0);
    wr(2'd1, 14'h0220);
    chk("R9 OR enables", 32'(enables), 32'h220);
    chk("R3 valid", 32'(valid), 1);
    chk("R4 line 5", 32'(line), 5);
    pulse_req(14'h0004);
    wr(2'd1, 14'h0004);
    chk("R4 lower line wins", 32'(line), 2);
    tick(3);
    chk("R5 held valid", 32'(valid), 1);
    chk("R5 flags kept", 32'(flags), 32'h24);
    ready = 1'b1; tick(); ready = 1'b0;
    chk("R6 flag cleared", 32'(flags), 32'h20);
    chk("R6 mask set", 32'(gmask), 1);
    chk("R11 masked no valid", 32'(valid), 0);
    tick(2);
    ret = 1'b1; tick(); ret = 1'b0;
    chk("R8 mask restored", 32'(gmask), 0);
    chk("R11 pending offered", 32'(line), 5);
    ready = 1'b1; req = 14'h0020; tick(); ready = 1'b0; req = '0;
    chk("R7 flag kept on edge", 32'(flags), 32'h20);
    ret = 1'b1; tick(); ret = 1'b0;
    ready = 1'b1; tick(); ready = 1'b0;
    wr(2'd0, '0);
    ret = 1'b1; tick(); ret = 1'b0;
    chk("R10 flag write", 32'(flags), 0);
    pulse_req(14'h3000);
    wr(2'd1, 14'h3000);
    chk("R4 timer line 12", 32'(line), 12);
    wr(2'd2, 14'h2FFF);
    chk("R9 AND enables", 32'(enables), 32'h2224);
    chk("R4 timer line 13", 32'(line), 13);
    wr_en = 1'b1; wr_op = 2'd0; wr_data = '0; req = 14'h0002;
    tick();
    wr_en = 1'b0; req = '0;
    chk("R10 edge beats flag write", 32'(flags), 32'h2);
    wr(2'd3, 14'h1);
    chk("R10 mask write", 32'(gmask), 1);

    for (int k = 0; k < 4000; k++) begin
      req   = N'($urandom & $urandom & $urandom);
      ready = ($urandom % 3) != 0;
      ret   = ($urandom % 6) == 0;
      wr_en = ($urandom % 8) == 0;
      wr_op = 2'($urandom);
      wr_data = N'($urandom);
      tick();
    end
    req = '0; ready = 1'b0; ret = 1'b0; wr_en = 1'b0;
    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired act=%0d exp=0", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule